// File: doc/BRIEF.md
# Kernel Segment Address Translator

This block sits at the front of address translation. For every access it chooses between three outcomes: the virtual address passes through untouched when translation is switched off; a kernel access to a selected 256 MB segment is relocated by a fixed 4-bit physical base; or the access is handed to a paged lookup unit. Paged lookups are steered to an instruction-side or a data-side lookup port, depending on the access kind.

The segment map is set by a 16-bit per-segment enable mask and two kernel-base words. Each word packs eight 4-bit bases: the low word serves segments 0 to 7 and the high word serves segments 8 to 15. The decision logic is combinational. With `OUT_REG` set to 1, which is the default, the result is registered once before it reaches the outputs.

Top module: `kseg_xlat`

## Requirements
- R1: When both `xlat_mode` bits are 0, translation is off: `paddr` equals `vaddr`, `full_perm` is 1, and `walk_req`, `walk_ifetch` and `walk_data` are 0.
- R2: Translation is on when either `xlat_mode` bit is 1. The values 01, 10 and 11 all behave the same.
- R3: With translation on, a kernel access (`is_user`=0) whose segment `vaddr[31:28]` has its bit set in `seg_map_en` gives `paddr` = {base nibble, `vaddr[27:0]`}, `full_perm`=1 and no page-lookup request.
- R4: The base nibble for segment s is taken from bits [4*(s mod 8)+3 : 4*(s mod 8)]. It comes from `kbase_lo` when s < 8 and from `kbase_hi` when s >= 8.
- R5: With translation on, a user access (`is_user`=1) always raises `walk_req`, whatever `seg_map_en` holds.
- R6: With translation on, a kernel access to a segment whose `seg_map_en` bit is 0 raises `walk_req`.
- R7: When `walk_req` is 1, `full_perm` is 0 and `paddr` is 0.
- R8: A page lookup with `acc_kind`=2 (execute) raises `walk_ifetch`. A page lookup with `acc_kind` 0 (read), 1 (write) or 3 raises `walk_data`. At most one of the two is high, and both are 0 when `walk_req` is 0.
- R9: With `OUT_REG`=1, outputs show the result for the inputs sampled at the previous rising clock edge. A synchronous reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 32 | Virtual address |
| is_user | input | 1 | 1 = user-mode access, 0 = kernel |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 treated as read |
| xlat_mode | input | 2 | The two translation-enable config bits |
| seg_map_en | input | 16 | Per-segment direct-mapping enable mask |
| kbase_lo | input | 32 | Packed base nibbles for segments 0-7 |
| kbase_hi | input | 32 | Packed base nibbles for segments 8-15 |
| paddr | output | 32 | Physical address (0 while a lookup is requested) |
| full_perm | output | 1 | Access granted with full permissions |
| walk_req | output | 1 | Paged lookup required |
| walk_ifetch | output | 1 | Lookup goes to the instruction port |
| walk_data | output | 1 | Lookup goes to the data port |

## Verification
The hardest case to reach is a wrong base nibble: the right nibble picked from the wrong word, or a neighbouring nibble picked from the right word. To expose it, the stimulus fills both base words with sixteen distinct nibble values and sweeps all sixteen segments with the mask fully set. The same addresses are then repeated in user mode and with single mask bits cleared, to show that mapping yields to page lookup. Each of the three enabled mode encodings is crossed with every access kind, so that a fault in the enable detection or in the port steering shows up at the outputs.

// File: rtl/kseg_pkg.sv
package kseg_pkg;

    localparam int ADDR_W = 32;
    localparam int SEG_W  = 4;
    localparam int NIB_W  = 4;
    localparam int NSEG   = 1 << SEG_W;
    localparam int HALF   = NSEG / 2;
    localparam int KB_W   = HALF * NIB_W;
    localparam int OFF_W  = ADDR_W - SEG_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PATH_FLAT = 2'd0,
        PATH_SEG  = 2'd1,
        PATH_PAGE = 2'd2
    } xlat_path_e;

    typedef struct packed {
        logic [ADDR_W-1:0] paddr;
        logic              full_perm;
        logic              walk_req;
        logic              walk_ifetch;
        logic              walk_data;
    } xlat_res_t;

    function automatic logic mode_on(input logic [1:0] mode);
        return |mode;
    endfunction

    function automatic logic is_fetch(input logic [1:0] kind);
        return kind == ACC_FETCH;
    endfunction

endpackage

// File: rtl/kseg_base_sel.sv
module kseg_base_sel
    import kseg_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [KB_W-1:0]  kbase_lo,
    input  logic [KB_W-1:0]  kbase_hi,
    output logic [NIB_W-1:0] base
);
    logic [NIB_W-1:0] nib [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_nib
        if (g < HALF) begin : g_lo
            assign nib[g] = kbase_lo[(g % HALF)*NIB_W +: NIB_W];
        end else begin : g_hi
            assign nib[g] = kbase_hi[(g % HALF)*NIB_W +: NIB_W];
        end
    end

    assign base = nib[seg];
endmodule

// File: rtl/kseg_decode.sv
module kseg_decode
    import kseg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              is_user,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        xlat_mode,
    input  logic [NSEG-1:0]   seg_map_en,
    input  logic [NIB_W-1:0]  base,
    output logic [SEG_W-1:0]  seg,
    output xlat_res_t         res
);
    xlat_path_e path;
    logic       on;

    assign seg = vaddr[ADDR_W-1 -: SEG_W];
    assign on  = mode_on(xlat_mode);

    always_comb begin
        if (!on)
            path = PATH_FLAT;
        else if (!is_user && seg_map_en[seg])
            path = PATH_SEG;
        else
            path = PATH_PAGE;
    end

    always_comb begin
        res = '0;
        unique case (path)
            PATH_FLAT: begin
                res.paddr     = vaddr;
                res.full_perm = 1'b1;
            end
            PATH_SEG: begin
                res.paddr     = {base, vaddr[OFF_W-1:0]};
                res.full_perm = 1'b1;
            end
            default: begin
                res.walk_req    = 1'b1;
                res.walk_ifetch = is_fetch(acc_kind);
                res.walk_data   = !is_fetch(acc_kind);
            end
        endcase
    end

    // R1
    flat_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (xlat_mode == 2'b00) |-> (res.paddr == vaddr && res.full_perm && !res.walk_req));
    // R3
    seg_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (res.full_perm && xlat_mode != 2'b00) |-> (res.paddr[OFF_W-1:0] == vaddr[OFF_W-1:0]));
    // R5
    user_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (xlat_mode != 2'b00 && is_user) |-> res.walk_req);
    // R7
    walk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        res.walk_req |-> (!res.full_perm && res.paddr == '0));
    // R8
    port_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        res.walk_req |-> ($countones({res.walk_ifetch, res.walk_data}) == 1));
    // R8
    port_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !res.walk_req |-> !(res.walk_ifetch || res.walk_data));
endmodule

// File: rtl/kseg_out_stage.sv
module kseg_out_stage
    import kseg_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  xlat_res_t d,
    output xlat_res_t q
);
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/kseg_xlat.sv
module kseg_xlat
    import kseg_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              is_user,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        xlat_mode,
    input  logic [NSEG-1:0]   seg_map_en,
    input  logic [KB_W-1:0]   kbase_lo,
    input  logic [KB_W-1:0]   kbase_hi,
    output logic [ADDR_W-1:0] paddr,
    output logic              full_perm,
    output logic              walk_req,
    output logic              walk_ifetch,
    output logic              walk_data
);
    logic [SEG_W-1:0] seg;
    logic [NIB_W-1:0] base;
    xlat_res_t        res_d;
    xlat_res_t        res_q;

    kseg_base_sel u_base (
        .seg      (seg),
        .kbase_lo (kbase_lo),
        .kbase_hi (kbase_hi),
        .base     (base)
    );

    kseg_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .vaddr      (vaddr),
        .is_user    (is_user),
        .acc_kind   (acc_kind),
        .xlat_mode  (xlat_mode),
        .seg_map_en (seg_map_en),
        .base       (base),
        .seg        (seg),
        .res        (res_d)
    );

    kseg_out_stage #(.OUT_REG(OUT_REG)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (res_d),
        .q   (res_q)
    );

    assign paddr       = res_q.paddr;
    assign full_perm   = res_q.full_perm;
    assign walk_req    = res_q.walk_req;
    assign walk_ifetch = res_q.walk_ifetch;
    assign walk_data   = res_q.walk_data;

    // R4
    seg_base_chk: assert property (@(posedge clk) disable iff (rst)
        (xlat_mode != 2'b00 && !is_user && seg_map_en[seg]) |->
        (res_d.paddr[ADDR_W-1 -: NIB_W] ==
         (seg[SEG_W-1] ? kbase_hi[seg[SEG_W-2:0]*NIB_W +: NIB_W]
                       : kbase_lo[seg[SEG_W-2:0]*NIB_W +: NIB_W])));
    // R6
    clear_bit_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (xlat_mode != 2'b00 && !is_user && !seg_map_en[seg]) |-> res_d.walk_req);
endmodule

// File: tb/kseg_xlat_test.sv
module kseg_xlat_test;

    typedef struct {
        logic [31:0] paddr;
        logic        full_perm;
        logic        walk_req;
        logic        walk_ifetch;
        logic        walk_data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] vaddr = '0;
    logic        is_user = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  xlat_mode = '0;
    logic [15:0] seg_map_en = '0;
    logic [31:0] kbase_lo = '0;
    logic [31:0] kbase_hi = '0;
    logic [31:0] paddr;
    logic        full_perm, walk_req, walk_ifetch, walk_data;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    kseg_xlat uut (
        .clk(clk), .rst(rst), .vaddr(vaddr), .is_user(is_user),
        .acc_kind(acc_kind), .xlat_mode(xlat_mode), .seg_map_en(seg_map_en),
        .kbase_lo(kbase_lo), .kbase_hi(kbase_hi), .paddr(paddr),
        .full_perm(full_perm), .walk_req(walk_req),
        .walk_ifetch(walk_ifetch), .walk_data(walk_data)
    );

    function automatic exp_t model(input logic [31:0] va, input logic usr,
                                   input logic [1:0] kind, input logic [1:0] mode,
                                   input logic [15:0] en, input logic [31:0] lo,
                                   input logic [31:0] hi, input string tag);
        exp_t e;
        int   s;
        logic [3:0] nb;
        e.paddr = '0; e.full_perm = 0; e.walk_req = 0;
        e.walk_ifetch = 0; e.walk_data = 0; e.tag = tag;
        s = int'(va[31:28]);
        if (mode == 2'b00) begin
            e.paddr = va; e.full_perm = 1;
        end else if (!usr && en[s]) begin
            nb = (s < 8) ? lo[(s%8)*4 +: 4] : hi[(s%8)*4 +: 4];
            e.paddr = {nb, va[27:0]}; e.full_perm = 1;
        end else begin
            e.walk_req = 1;
            if (kind == 2'd2) e.walk_ifetch = 1;
            else              e.walk_data = 1;
        end
        return e;
    endfunction

    task automatic drive(input logic [31:0] va, input logic usr, input logic [1:0] kind,
                         input logic [1:0] mode, input logic [15:0] en, input string tag);
        @(negedge clk);
        vaddr = va; is_user = usr; acc_kind = kind; xlat_mode = mode; seg_map_en = en;
        sb.push_back(model(va, usr, kind, mode, en, kbase_lo, kbase_hi, tag));
    endtask

    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            #2;
            e = sb.pop_front();
            n_run++;
            if (paddr !== e.paddr || full_perm !== e.full_perm || walk_req !== e.walk_req ||
                walk_ifetch !== e.walk_ifetch || walk_data !== e.walk_data) begin
                n_fail++;
                $display("FAIL %s: got paddr=%h perm=%b walk=%b i=%b d=%b exp paddr=%h perm=%b walk=%b i=%b d=%b",
                         e.tag, paddr, full_perm, walk_req, walk_ifetch, walk_data,
                         e.paddr, e.full_perm, e.walk_req, e.walk_ifetch, e.walk_data);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        n_run++;
        if (paddr !== '0 || full_perm !== 0 || walk_req !== 0 || walk_ifetch !== 0 || walk_data !== 0) begin
            n_fail++;
            $display("FAIL R9: reset outputs paddr=%h perm=%b walk=%b exp all zero", paddr, full_perm, walk_req);
        end
        rst = 1'b0;
        kbase_lo = 32'h7E3A_C519;
        kbase_hi = 32'h62DB_F408;

        // R1: translation off, even with mapping bits and user mode
        drive(32'h1234_5678, 1'b0, 2'd0, 2'b00, 16'hFFFF, "R1");
        drive(32'hF00D_BEEF, 1'b1, 2'd2, 2'b00, 16'hFFFF, "R1");
        // R3 R4: sweep all segments kernel, full mask
        for (int s = 0; s < 16; s++)
            drive({s[3:0], 28'hABC_DEF1 ^ 28'(s * 32'h111_1111)}, 1'b0, 2'd0, 2'b11, 16'hFFFF, "R4");
        // R2: each enabled encoding, segment and page paths
        drive(32'h3000_0040, 1'b0, 2'd1, 2'b01, 16'h0008, "R2");
        drive(32'h3000_0040, 1'b0, 2'd1, 2'b10, 16'h0008, "R2");
        drive(32'h3000_0040, 1'b0, 2'd1, 2'b11, 16'h0008, "R3");
        drive(32'h4000_0040, 1'b0, 2'd1, 2'b01, 16'h0008, "R2");
        // R5: user never mapped
        for (int s = 0; s < 16; s++)
            drive({s[3:0], 28'h0123_456}, 1'b1, 2'd1, 2'b10, 16'hFFFF, "R5");
        // R6: single cleared bit
        drive(32'h9FFF_FFFF, 1'b0, 2'd0, 2'b01, 16'hFDFF, "R6");
        drive(32'h8FFF_FFFF, 1'b0, 2'd0, 2'b01, 16'hFDFF, "R6");
        drive(32'h0000_0000, 1'b0, 2'd0, 2'b01, 16'hFFFE, "R6");
        // R7 R8: steering by access kind on lookups
        for (int m = 1; m < 4; m++)
            for (int k = 0; k < 4; k++)
                drive(32'h5A5A_0000 + 32'(k), 1'(k & 1), 2'(k), 2'(m), 16'h0000, "R8");
        drive(32'hC000_1000, 1'b0, 2'd2, 2'b01, 16'h1000, "R7");
        // R9: back-to-back changes then reset mid-stream
        drive(32'hE000_0001, 1'b0, 2'd0, 2'b11, 16'h4000, "R9");
        drive(32'hE000_0002, 1'b1, 2'd0, 2'b11, 16'h4000, "R9");
        @(negedge clk);
        wait (sb.size() == 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        n_run++;
        if (paddr !== '0 || full_perm !== 0 || walk_req !== 0) begin
            n_fail++;
            $display("FAIL R9: after reset paddr=%h perm=%b walk=%b exp zero", paddr, full_perm, walk_req);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: run did not finish, exp completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule